// File: doc/BRIEF.md
# Six-State Moore Sequencer

This block is a synchronous finite state machine with one serial input bit and one Moore output bit. It holds one of six states, each with a fixed 3-bit binary code. On each rising clock edge it samples the input and moves to a new state according to a fixed transition table. The output bit is high in exactly one state and low in all the others.

Both the output bit and the state code come straight from registers. The input therefore reaches the outputs only through a clock edge. The current state code is driven on a port, so a reference model of the table can follow the machine step by step. An active-high synchronous reset returns the machine to the start state. The two unused codes (110 and 111) lead back to the start state on the next edge.

Top module: `seq_moore_six`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `state_code` is 000 and `z_out` is 0.
- R2: From code 000, the next state is 010 when `x_in` is 0 and 001 when `x_in` is 1.
- R3: From code 001, the next state is 101 when `x_in` is 0 and 000 when `x_in` is 1.
- R4: From code 010, the next state is 011 when `x_in` is 0 and 001 when `x_in` is 1.
- R5: From code 011, the state stays at 011 when `x_in` is 0 and goes to 100 when `x_in` is 1.
- R6: From code 100, the state stays at 100 when `x_in` is 0 and goes to 011 when `x_in` is 1.
- R7: From code 101, the next state is 100 when `x_in` is 0 and 000 when `x_in` is 1.
- R8: `z_out` is 1 exactly when `state_code` is 100, and 0 for every other code.
- R9: After a reset, `state_code` never shows 110 or 111. Either of those codes leads to 000 on the next edge, and `z_out` is 0 while the register holds one.
- R10: `x_in` is sampled only at the rising edge. If it changes between edges, `z_out` and `state_code` stay as they are until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial input bit sampled at each edge |
| z_out | output | 1 | Registered Moore output, high only in state 100 |
| state_code | output | 3 | Registered current state code |

## Verification
The assertions assume that reset is held high through the first rising edge, so the register holds a known state before any transition check is enabled. They also assume that `x_in` is settled at each rising edge. The bench meets both conditions. It asserts reset from time zero and changes `x_in` only on falling edges, or well away from the rising edge when it probes the mid-cycle glitch case. The stimulus takes each of the twelve table entries on purpose, then runs a long pseudo-random input stream with a reset applied partway through.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int STATE_W = 3;
  localparam int REG_W   = STATE_W + 1;

  localparam logic [STATE_W-1:0] ST_0 = 3'b000;
  localparam logic [STATE_W-1:0] ST_1 = 3'b001;
  localparam logic [STATE_W-1:0] ST_2 = 3'b010;
  localparam logic [STATE_W-1:0] ST_3 = 3'b011;
  localparam logic [STATE_W-1:0] ST_4 = 3'b100;
  localparam logic [STATE_W-1:0] ST_5 = 3'b101;

  localparam logic [STATE_W-1:0] ST_START = ST_0;
  localparam logic [STATE_W-1:0] ST_FLAG  = ST_4;
endpackage

// File: rtl/seq_next_state.sv
module seq_next_state
  import seq_pkg::*;
(
  input  logic [STATE_W-1:0] cur_state,
  input  logic               x_bit,
  output logic [STATE_W-1:0] nxt_state
);
  always_comb begin
    nxt_state = ST_START;
    unique case (cur_state)
      ST_0:    nxt_state = x_bit ? ST_1 : ST_2;
      ST_1:    nxt_state = x_bit ? ST_0 : ST_5;
      ST_2:    nxt_state = x_bit ? ST_1 : ST_3;
      ST_3:    nxt_state = x_bit ? ST_4 : ST_3;
      ST_4:    nxt_state = x_bit ? ST_3 : ST_4;
      ST_5:    nxt_state = x_bit ? ST_0 : ST_4;
      default: nxt_state = ST_START;
    endcase
  end
endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
  import seq_pkg::*;
#(
  parameter logic [STATE_W-1:0] MATCH_CODE = ST_FLAG
) (
  input  logic [STATE_W-1:0] state_in,
  output logic               flag
);
  always_comb flag = (state_in == MATCH_CODE);
endmodule

// File: rtl/seq_reg.sv
module seq_reg #(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] RST_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/seq_moore_six.sv
module seq_moore_six
  import seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               x_in,
  output logic               z_out,
  output logic [STATE_W-1:0] state_code
);
  logic [STATE_W-1:0] cur_s;
  logic [STATE_W-1:0] nxt_s;
  logic               z_next;
  logic [REG_W-1:0]   reg_d;
  logic [REG_W-1:0]   reg_q;

  seq_next_state u_next (
    .cur_state (cur_s),
    .x_bit     (x_in),
    .nxt_state (nxt_s)
  );

  // Decode from the next state so that z is registered alongside the state.
  seq_out_decode #(.MATCH_CODE(ST_FLAG)) u_dec (
    .state_in (nxt_s),
    .flag     (z_next)
  );

  assign reg_d = {z_next, nxt_s};

  seq_reg #(.WIDTH(REG_W), .RST_VAL({1'b0, ST_START})) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (reg_d),
    .q   (reg_q)
  );

  assign cur_s      = reg_q[STATE_W-1:0];
  assign z_out      = reg_q[REG_W-1];
  assign state_code = cur_s;
endmodule

// File: rtl/seq_moore_six_checker.sv
module seq_moore_six_checker
  import seq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               x_in,
  input logic               z_out,
  input logic [STATE_W-1:0] state_code
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (state_code == ST_START && !z_out));

  assert_s0_R2: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_0) |=> (state_code == ($past(x_in) ? ST_1 : ST_2)));

  assert_s1_R3: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_1) |=> (state_code == ($past(x_in) ? ST_0 : ST_5)));

  assert_s2_R4: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_2) |=> (state_code == ($past(x_in) ? ST_1 : ST_3)));

  assert_s3_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_3) |=> (state_code == ($past(x_in) ? ST_4 : ST_3)));

  assert_s4_R6: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_4) |=> (state_code == ($past(x_in) ? ST_3 : ST_4)));

  assert_s5_R7: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_5) |=> (state_code == ($past(x_in) ? ST_0 : ST_4)));

  assert_z_match_R8: assert property (@(posedge clk) disable iff (rst)
    z_out == (state_code == ST_FLAG));

  assert_no_unused_R9: assert property (@(posedge clk) disable iff (rst)
    state_code <= ST_5);
endmodule

bind seq_moore_six seq_moore_six_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .x_in       (x_in),
  .z_out      (z_out),
  .state_code (state_code)
);

// File: tb/seq_moore_six_bench.sv
`timescale 1ns/1ps
module seq_moore_six_bench;
  typedef struct {
    logic [2:0] st;
    logic       z;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x_in = 1'b0;
  logic       z_out;
  logic [2:0] state_code;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;
  exp_t q[$];
  logic [2:0] model_s = 3'b000;

  always #4 clk = ~clk;

  seq_moore_six u_seq_moore_six (
    .clk        (clk),
    .rst        (rst),
    .x_in       (x_in),
    .z_out      (z_out),
    .state_code (state_code)
  );

  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic x);
    case (s)
      3'd0:    return x ? 3'd1 : 3'd2;
      3'd1:    return x ? 3'd0 : 3'd5;
      3'd2:    return x ? 3'd1 : 3'd3;
      3'd3:    return x ? 3'd4 : 3'd3;
      3'd4:    return x ? 3'd3 : 3'd4;
      3'd5:    return x ? 3'd0 : 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic r, input logic x);
    exp_t e;
    @(negedge clk);
    rst  = r;
    x_in = x;
    if (r) begin
      model_s = 3'd0;
      e.tag = "R1";
    end else begin
      e.tag = tag_of(model_s);
      model_s = ref_next(model_s, x);
    end
    e.st = model_s;
    e.z  = (model_s == 3'd4);
    q.push_back(e);
  endtask

  // Monitor: pops one expected item per edge and compares.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (state_code !== e.st) begin
        n_errors++;
        $display("FAIL %s state_code got %b exp %b", e.tag, state_code, e.st);
      end
      n_checks++;
      if (z_out !== e.z) begin
        n_errors++;
        $display("FAIL R8 (%s) z_out got %b exp %b", e.tag, z_out, e.z);
      end
      n_checks++;
      if (!(state_code inside {[3'd0:3'd5]})) begin
        n_errors++;
        $display("FAIL R9 state_code got %b exp <= 101", state_code);
      end
    end
  end

  // R10: toggle x mid-cycle and confirm outputs hold until the next edge.
  task automatic glitch_probe();
    logic [2:0] s0;
    logic       z0;
    @(posedge clk);
    #2;
    s0 = state_code;
    z0 = z_out;
    x_in = ~x_in;
    #1;
    x_in = ~x_in;
    #0.5;
    n_checks++;
    if (state_code !== s0 || z_out !== z0) begin
      n_errors++;
      $display("FAIL R10 got state %b z %b exp state %b z %b",
               state_code, z_out, s0, z0);
    end
  endtask

  initial begin
    logic [7:0] lfsr = 8'hA5;
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // Directed walk over every table entry.
    step(1'b0, 1'b1); // 0->1
    step(1'b0, 1'b1); // 1->0
    step(1'b0, 1'b0); // 0->2
    step(1'b0, 1'b1); // 2->1
    step(1'b0, 1'b0); // 1->5
    step(1'b0, 1'b1); // 5->0
    step(1'b0, 1'b1); // 0->1
    step(1'b0, 1'b0); // 1->5
    step(1'b0, 1'b0); // 5->4
    step(1'b0, 1'b0); // 4->4
    glitch_probe();
    step(1'b0, 1'b1); // 4->3
    step(1'b0, 1'b0); // 3->3
    step(1'b0, 1'b1); // 3->4
    step(1'b0, 1'b1); // 4->3
    glitch_probe();
    step(1'b0, 1'b1); // 3->4
    step(1'b1, 1'b1); // reset from S4
    step(1'b0, 1'b0); // 0->2
    step(1'b0, 1'b0); // 2->3
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((i == 150), lfsr[0]);
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule